// File: doc/BRIEF.md
# Deferred-Write Store Buffer

This block sits beside a pipelined data cache whose tag comparison finishes only after the data array has been read. A store cannot write the array right away, because a write cannot be undone if the line is absent. The block therefore keeps one store (word address, data, byte enables) in a single-entry buffer. The cache pipeline reports the tag result for that store at least one cycle after the store arrives. On a hit the entry becomes confirmed. It is written to the array only in a cycle where the array has no other work. Such a cycle is the access slot of the next store, or an idle cycle once a flush has been asked for. On a miss the entry is dropped and a one-cycle miss flag is raised.

Each load on the shared request port reads the array and is also compared against the buffered word address. Bytes the buffered store covers are taken from the buffer, and all other bytes come from the array. The merged word appears one cycle after the load request, together with the array read data. The environment must not present a new store while the buffered one still waits for its tag result.

Top module: `delayed_store_buf`

## Requirements
- R1: A store into an empty buffer causes no array write in its own cycle, and `busy` is high from the next cycle.
- R2: The array write strobe never carries an entry whose tag result has not yet been reported as a hit.
- R3: A tag result of miss for the waiting entry discards it without any array write. `missFlag` is high for exactly the following cycle, and in that cycle `busy` is low.
- R4: After a hit the entry stays in the buffer, with `busy` high, until a drain slot comes.
- R5: A store that arrives while a confirmed entry is held writes the old entry's address, data and byte enables to the array in that same cycle. The new store then takes the buffer.
- R6: A flush request is remembered until the buffer is empty. The confirmed entry drains in the first cycle with no request. `busy` falls the cycle after that drain, and the array then holds every store that hit.
- R7: A load to the buffered word gives `loadValid` and `loadData` one cycle after the request. Byte i (bits 8i+7..8i) comes from the buffer when enable bit i of the buffered store is set, and from `arrRdData` otherwise.
- R8: A load to any other word returns `arrRdData` unchanged.
- R9: A tag result presented while no entry awaits one has no effect on `busy`, `missFlag` or the array.
- R10: The array read strobe is high exactly in load request cycles, with the request address, and is never high together with the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| reqValid | input | 1 | Request present this cycle |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqAddr | input | ADDR_W | Word address of the request |
| reqData | input | DATA_W | Store data |
| reqBe | input | DATA_W/8 | Store byte enables |
| tagValid | input | 1 | Tag result for the waiting store is presented |
| tagHit | input | 1 | Tag result: 1 = hit, 0 = miss |
| flush | input | 1 | Ask for the buffered entry to be drained |
| arrRdEn | output | 1 | Array read strobe |
| arrRdAddr | output | ADDR_W | Array read word address |
| arrRdData | input | DATA_W | Array read data, one cycle after the strobe |
| arrWrEn | output | 1 | Array write strobe |
| arrWrAddr | output | ADDR_W | Array write word address |
| arrWrData | output | DATA_W | Array write data |
| arrWrBe | output | DATA_W/8 | Array write byte enables |
| loadValid | output | 1 | Load result valid |
| loadData | output | DATA_W | Merged load result |
| missFlag | output | 1 | One-cycle pulse after a tag miss |
| busy | output | 1 | Buffer holds an entry |

## Verification
If the block loses its confirmed state, a store can reach the array before its hit. It can also go missing from the array for good. This shows at the write port in that same cycle, or after the final flush when the array is compared with the hit-only memory image. If the buffered address or enables are wrong, a load returns a wrong byte on the very next cycle. The random stimulus keeps addresses to a few words so that forwarding, partial merges and drains collide often. If the miss handling or the flush memory is broken, `missFlag` or `busy` shows it within one cycle.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic capture;    // latch the incoming store
    logic drain;      // write held entry to the array
    logic entryLive;  // buffer holds an entry (for load match)
    logic loadReq;    // load request this cycle
  } dsbStrobes_t;
endpackage

// File: rtl/dsb_ctrl.sv
module dsb_ctrl
  import dsb_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic        reqStore,
  input  logic        tagValid,
  input  logic        tagHit,
  input  logic        flush,
  output dsbStrobes_t strb,
  output logic        bufValid,
  output logic        bufConf,
  output logic        missFlag
);
  logic flushPend;
  logic isStore, isLoad, ready, flushWant, tagSeen, missNow;
  logic validNext, confNext;

  always_comb begin
    isStore   = reqValid && reqStore;
    isLoad    = reqValid && !reqStore;
    ready     = bufValid && bufConf;
    flushWant = flush || flushPend;
    tagSeen   = tagValid && bufValid && !bufConf;
    missNow   = tagSeen && !tagHit;
    strb.drain     = ready && (isStore || (!reqValid && flushWant));
    strb.capture   = isStore;
    strb.entryLive = bufValid;
    strb.loadReq   = isLoad;
    validNext = isStore || (bufValid && !strb.drain && !missNow);
    confNext  = isStore ? 1'b0 : (bufConf || (tagSeen && tagHit));
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      bufValid  <= 1'b0;
      bufConf   <= 1'b0;
      flushPend <= 1'b0;
      missFlag  <= 1'b0;
    end else begin
      bufValid  <= validNext;
      bufConf   <= confNext && validNext;
      flushPend <= flushWant && validNext;
      missFlag  <= missNow;
    end
  end
endmodule

// File: rtl/dsb_data.sv
module dsb_data
  import dsb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dsbStrobes_t       strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [BE_W-1:0]   reqBe,
  input  logic [DATA_W-1:0] arrRdData,
  output logic [ADDR_W-1:0] arrRdAddr,
  output logic              arrRdEn,
  output logic              arrWrEn,
  output logic [ADDR_W-1:0] arrWrAddr,
  output logic [DATA_W-1:0] arrWrData,
  output logic [BE_W-1:0]   arrWrBe,
  output logic              loadValid,
  output logic [DATA_W-1:0] loadData
);
  logic [ADDR_W-1:0] bufAddr;
  logic [DATA_W-1:0] bufData;
  logic [BE_W-1:0]   bufBe;
  logic [DATA_W-1:0] fwdData;
  logic [BE_W-1:0]   fwdMask;
  logic              addrMatch;

  assign addrMatch = strb.entryLive && (bufAddr == reqAddr);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      bufAddr   <= '0;
      bufData   <= '0;
      bufBe     <= '0;
      fwdData   <= '0;
      fwdMask   <= '0;
      loadValid <= 1'b0;
    end else begin
      if (strb.capture) begin
        bufAddr <= reqAddr;
        bufData <= reqData;
        bufBe   <= reqBe;
      end
      loadValid <= strb.loadReq;
      fwdData   <= bufData;
      fwdMask   <= (strb.loadReq && addrMatch) ? bufBe : '0;
    end
  end

  for (genvar i = 0; i < BE_W; i++) begin : g_byte
    assign loadData[8*i +: 8] = fwdMask[i] ? fwdData[8*i +: 8] : arrRdData[8*i +: 8];
  end

  assign arrRdEn   = strb.loadReq;
  assign arrRdAddr = reqAddr;
  assign arrWrEn   = strb.drain;
  assign arrWrAddr = bufAddr;
  assign arrWrData = bufData;
  assign arrWrBe   = bufBe;
endmodule

// File: rtl/delayed_store_buf.sv
module delayed_store_buf
  import dsb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqStore,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [BE_W-1:0]   reqBe,
  input  logic              tagValid,
  input  logic              tagHit,
  input  logic              flush,
  output logic              arrRdEn,
  output logic [ADDR_W-1:0] arrRdAddr,
  input  logic [DATA_W-1:0] arrRdData,
  output logic              arrWrEn,
  output logic [ADDR_W-1:0] arrWrAddr,
  output logic [DATA_W-1:0] arrWrData,
  output logic [BE_W-1:0]   arrWrBe,
  output logic              loadValid,
  output logic [DATA_W-1:0] loadData,
  output logic              missFlag,
  output logic              busy
);
  dsbStrobes_t strb;
  logic bufValid, bufConf;

  dsb_ctrl u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqStore(reqStore),
    .tagValid(tagValid), .tagHit(tagHit), .flush(flush), .strb(strb),
    .bufValid(bufValid), .bufConf(bufConf), .missFlag(missFlag)
  );

  dsb_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rst(rst), .strb(strb), .reqAddr(reqAddr), .reqData(reqData),
    .reqBe(reqBe), .arrRdData(arrRdData), .arrRdAddr(arrRdAddr), .arrRdEn(arrRdEn),
    .arrWrEn(arrWrEn), .arrWrAddr(arrWrAddr), .arrWrData(arrWrData),
    .arrWrBe(arrWrBe), .loadValid(loadValid), .loadData(loadData)
  );

  assign busy = bufValid;
endmodule

// File: rtl/dsb_chk.sv
module dsb_chk (
  input logic clk,
  input logic rst,
  input logic reqValid,
  input logic reqStore,
  input logic tagValid,
  input logic tagHit,
  input logic arrWrEn,
  input logic arrRdEn,
  input logic loadValid,
  input logic missFlag,
  input logic busy,
  input logic bufConf
);
  // R2
  wr_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    arrWrEn |-> (busy && bufConf));
  // R2
  no_store_while_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !bufConf) |-> !(reqValid && reqStore));
  // R3
  miss_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (tagValid && !tagHit && busy && !bufConf) |=> (missFlag && !busy));
  // R5
  store_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqStore && busy && bufConf) |-> arrWrEn);
  // R1
  store_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqStore) |=> busy);
  // R7
  load_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqStore) |=> loadValid);
  // R9
  tag_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (tagValid && !busy) |=> !missFlag);
  // R10
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(arrWrEn && arrRdEn));
endmodule

bind delayed_store_buf dsb_chk u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqStore(reqStore),
  .tagValid(tagValid), .tagHit(tagHit), .arrWrEn(arrWrEn), .arrRdEn(arrRdEn),
  .loadValid(loadValid), .missFlag(missFlag), .busy(busy), .bufConf(bufConf)
);

// File: tb/tb_delayed_store_buf.sv
`timescale 1ns/1ps
module tb_delayed_store_buf;
  localparam int AW = 10, DW = 32, BW = DW / 8;

  logic clk = 1'b0, rst = 1'b1;
  logic reqValid = 0, reqStore = 0, tagValid = 0, tagHit = 0, flush = 0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic [BW-1:0] reqBe = '0;
  logic arrRdEn, arrWrEn, loadValid, missFlag, busy;
  logic [AW-1:0] arrRdAddr, arrWrAddr;
  logic [DW-1:0] arrRdData, arrWrData, loadData;
  logic [BW-1:0] arrWrBe;

  always #2.5 clk = ~clk;

  delayed_store_buf dut (.*);

  // array model: registered read, byte-enabled write
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic [DW-1:0] rdReg = '0;
  assign arrRdData = rdReg;
  always @(posedge clk) begin
    if (arrRdEn) rdReg <= mem[arrRdAddr];
    if (arrWrEn)
      for (int i = 0; i < BW; i++)
        if (arrWrBe[i]) mem[arrWrAddr][8*i +: 8] <= arrWrData[8*i +: 8];
  end

  // reference state
  logic [DW-1:0] gm [0:(1<<AW)-1];
  logic mValid = 0, mConf = 0, mFlush = 0;
  logic [AW-1:0] mAddr = '0;
  logic [DW-1:0] mData = '0;
  logic [BW-1:0] mBe = '0;
  logic expLV = 0, expMiss = 0;
  logic [DW-1:0] expLD = '0;
  int nChk = 0, nFail = 0;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] base, input logic [DW-1:0] d,
                                          input logic [BW-1:0] be);
    logic [DW-1:0] r = base;
    for (int i = 0; i < BW; i++) if (be[i]) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic rv, input logic rs, input logic [AW-1:0] ra,
                      input logic [DW-1:0] rd, input logic [BW-1:0] rb,
                      input logic tv, input logic th, input logic fl);
    logic expWr, tagSeen;
    @(negedge clk);
    // registered outputs from the previous edge
    chk("R3 R9 missFlag", {31'b0, missFlag}, {31'b0, expMiss});
    chk("R7 loadValid", {31'b0, loadValid}, {31'b0, expLV});
    if (expLV) chk("R7 R8 loadData", loadData, expLD);
    reqValid = rv; reqStore = rs; reqAddr = ra; reqData = rd; reqBe = rb;
    tagValid = tv; tagHit = th; flush = fl;
    #1;
    expWr = mValid && mConf && ((rv && rs) || (!rv && (fl || mFlush)));
    chk("R1 R4 busy", {31'b0, busy}, {31'b0, mValid});
    chk("R2 R5 R6 wrEn", {31'b0, arrWrEn}, {31'b0, expWr});
    if (expWr) begin
      chk("R5 R6 wrAddr", {22'b0, arrWrAddr}, {22'b0, mAddr});
      chk("R5 R6 wrData", arrWrData, mData);
      chk("R5 R6 wrBe", {28'b0, arrWrBe}, {28'b0, mBe});
    end
    chk("R10 rdEn", {31'b0, arrRdEn}, {31'b0, rv && !rs});
    if (rv && !rs) chk("R10 rdAddr", {22'b0, arrRdAddr}, {22'b0, ra});
    // expectations for the next cycle
    expLV = rv && !rs;
    expLD = (mValid && !mConf && mAddr == ra) ? merge(gm[ra], mData, mBe) : gm[ra];
    tagSeen = tv && mValid && !mConf;
    expMiss = tagSeen && !th;
    if (tagSeen && th) begin mConf = 1; gm[mAddr] = merge(gm[mAddr], mData, mBe); end
    if (tagSeen && !th) mValid = 0;
    if (expWr) mValid = 0;
    if (rv && rs) begin mValid = 1; mConf = 0; mAddr = ra; mData = rd; mBe = rb; end
    mFlush = (fl || mFlush) && mValid;
  endtask

  task automatic idle(input logic fl);
    step(0, 0, '0, '0, '0, 0, 0, fl);
  endtask

  initial begin
    #(200000 * 5);
    nFail++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    int tagWait;
    void'($urandom(32'd1234));
    for (int a = 0; a < (1 << AW); a++) begin
      mem[a] = 32'hA000_0000 + a * 32'h0101;
      gm[a]  = 32'hA000_0000 + a * 32'h0101;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // reset state
    chk("R1 reset busy", {31'b0, busy}, 32'd0);
    chk("R2 reset wrEn", {31'b0, arrWrEn}, 32'd0);
    chk("R3 reset miss", {31'b0, missFlag}, 32'd0);
    chk("R7 reset loadValid", {31'b0, loadValid}, 32'd0);

    // directed corner cases
    step(1, 1, 10'd3, 32'h1122_3344, 4'hF, 0, 0, 0); // R1 store into empty
    step(1, 0, 10'd3, '0, '0, 0, 0, 0);               // R7 forward while awaiting tag
    step(0, 0, '0, '0, '0, 1, 1, 1);                   // hit with flush request, idle: drains next idle
    step(1, 0, 10'd3, '0, '0, 0, 0, 0);               // R7 forward confirmed entry
    idle(0);                                           // R6 remembered flush drains
    step(1, 1, 10'd5, 32'hDEAD_BEEF, 4'b0101, 0, 0, 0);
    step(1, 0, 10'd5, '0, '0, 0, 0, 0);               // R7 partial merge
    step(0, 0, '0, '0, '0, 1, 1, 0);                   // hit
    idle(0); idle(0);                                  // R4 held
    step(1, 1, 10'd6, 32'h0BAD_F00D, 4'b1000, 0, 0, 0); // R5 drain in store slot
    step(0, 0, '0, '0, '0, 1, 0, 0);                   // R3 miss
    step(1, 0, 10'd6, '0, '0, 1, 1, 0);               // R9 stray tag, R8 load after miss
    step(1, 0, 10'd2, '0, '0, 0, 0, 0);               // R8 unrelated word
    step(1, 1, 10'd7, 32'h5555_AAAA, 4'b0011, 0, 0, 0);
    step(0, 0, '0, '0, '0, 1, 1, 0);
    step(1, 0, 10'd1, '0, '0, 0, 0, 1);               // R6 flush waits while request present
    idle(0); idle(0);

    // constrained random
    tagWait = 0;
    for (int n = 0; n < 3000; n++) begin
      logic rv, rs, tv, th, fl;
      rv = ($urandom % 4) != 0;
      rs = ($urandom % 2) == 1;
      tv = 0; th = 0;
      fl = ($urandom % 16) == 0;
      if (mValid && !mConf) begin
        rs = 0;
        if (tagWait <= 1) begin tv = 1; th = ($urandom % 8) != 0; end
        else tagWait--;
      end else if (($urandom % 10) == 0) begin
        tv = 1; th = $urandom % 2;
      end
      if (rv && rs) tagWait = 1 + ($urandom % 3);
      step(rv, rs, 10'($urandom % 8), $urandom, 4'($urandom), tv, th, fl);
    end

    // settle: resolve any waiting tag, then flush
    if (mValid && !mConf) step(0, 0, '0, '0, '0, 1, 1, 0);
    for (int k = 0; k < 6; k++) idle(1);
    idle(0);
    @(negedge clk);
    chk("R6 busy after flush", {31'b0, busy}, 32'd0);
    for (int a = 0; a < 8; a++) chk("R6 array image", mem[a], gm[a]);
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule